// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block holds one 64-bit time value taken from a free-running time counter at the moment a packet classifier flags a matching timing event packet. A one-cycle strobe from the classifier, together with a 16-bit sequence number drawn from that packet, is the capture trigger. Once a value is held, the block marks it valid and ignores every later strobe until software has read it and re-armed the latch by writing a one to the valid flag.

Software reaches the block through a small register port with four word addresses: a status word carrying the valid flag and the sequence number, the low and high 32-bit halves of the held time, and a 3-bit enable field that gates capture. One instance sits on the receive path and a second on the transmit path. Re-arming through the status write also serves to throw away a stale value whenever timestamping is switched on or its setup changes.

Top module: `ts_capture`

## Requirements
- R1: After a synchronous reset the valid flag, the held time, the held sequence number and the enable field are all zero, so every register reads 0.
- R2: With the latch armed (valid clear) and the enable field nonzero, a capture strobe stores `time_in` and `seq_in` at that clock edge and sets the valid flag; the status word at address 0 then reads the sequence number in bits 15:0, the valid flag in bit 16 and zero elsewhere.
- R3: Address 1 reads bits 31:0 of the held time and address 2 reads bits 63:32.
- R4: While the valid flag is set, capture strobes are ignored: the held time, the held sequence number and the flag do not change.
- R5: A write to address 0 with bit 16 set clears the valid flag and re-arms the latch; a write to address 0 with bit 16 clear has no effect. The held time and sequence stay readable after the clear but are to be treated as invalid.
- R6: The enable field is written and read at address 3 in bits 2:0; the value 0 blocks capture, and any nonzero value (3, 5 and 7 in normal use) allows it.
- R7: When a re-arm write and a capture strobe fall in the same cycle, the re-arm wins: the valid flag ends clear and the strobe is dropped, whatever the flag was before.
- R8: `reg_rdata` is registered: it shows the register addressed in a cycle with `reg_rd` high after the next clock edge, and it keeps its value in cycles without `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_strobe | input | 1 | One-cycle match pulse from the packet classifier |
| time_in | input | 64 | Current value of the time counter |
| seq_in | input | 16 | Sequence number of the matched packet |
| reg_addr | input | 2 | Register word address (0 status, 1 time low, 2 time high, 3 enable) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 32-bit register word, a 64-bit time input and a 16-bit sequence field. With those widths the sequence number fills the whole lower half of the status word right up against the valid flag at bit 16, so an all-ones sequence exposes any bleed into the flag, and time values whose two halves differ expose swapped or misaligned half reads. Every nonzero enable value used in practice is exercised, as are re-arm and strobe arriving together with the flag both set and clear.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  typedef enum logic [1:0] {
    ADR_STAT = 2'd0,
    ADR_TLO  = 2'd1,
    ADR_THI  = 2'd2,
    ADR_EN   = 2'd3
  } ts_addr_e;

  localparam int VALID_POS = 16;
  localparam int EN_W      = 3;
endpackage

// File: rtl/ts_cap_ctrl.sv
module ts_cap_ctrl
  import ts_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic            wr_valid_bit,
  input  logic [EN_W-1:0] wr_en_bits,
  output logic [EN_W-1:0] en_q,
  output logic            cap_en,
  output logic            clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (reg_wr && reg_addr == ADR_EN) begin
      en_q <= wr_en_bits;
    end
  end

  always_comb begin
    cap_en = (en_q != '0);
    clr    = reg_wr && (reg_addr == ADR_STAT) && wr_valid_bit;
  end
endmodule

// File: rtl/ts_cap_latch.sv
module ts_cap_latch #(
  parameter int TIME_W = 64,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [TIME_W-1:0] time_in,
  input  logic [SEQ_W-1:0]  seq_in,
  input  logic              cap_en,
  input  logic              clr,
  output logic              valid_q,
  output logic [TIME_W-1:0] time_q,
  output logic [SEQ_W-1:0]  seq_q
);
  logic take;

  always_comb take = strobe && cap_en && !valid_q && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      time_q  <= '0;
      seq_q   <= '0;
    end else begin
      if (clr) begin
        valid_q <= 1'b0;
      end else if (take) begin
        valid_q <= 1'b1;
      end
      if (take) begin
        time_q <= time_in;
        seq_q  <= seq_in;
      end
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe && cap_en && !valid_q && !clr) |=>
      (valid_q && time_q == $past(time_in) && seq_q == $past(seq_in)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr) |=> (valid_q && $stable(time_q) && $stable(seq_q)));

  assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_q);

  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !valid_q) |=> (!valid_q && $stable(time_q)));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && strobe) |=> (!valid_q && $stable(time_q)));
endmodule

// File: rtl/ts_cap_rdmux.sv
module ts_cap_rdmux
  import ts_cap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd,
  input  logic [1:0]          addr,
  input  logic                valid,
  input  logic [2*DATA_W-1:0] time_q,
  input  logic [SEQ_W-1:0]    seq_q,
  input  logic [EN_W-1:0]     en_q,
  output logic [DATA_W-1:0]   rdata_q
);
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] en_w;
  logic [DATA_W-1:0] sel_w;

  always_comb begin
    stat_w                 = '0;
    stat_w[SEQ_W-1:0]      = seq_q;
    stat_w[VALID_POS]      = valid;
    en_w                   = '0;
    en_w[EN_W-1:0]         = en_q;
    case (ts_addr_e'(addr))
      ADR_STAT: sel_w = stat_w;
      ADR_TLO:  sel_w = time_q[DATA_W-1:0];
      ADR_THI:  sel_w = time_q[2*DATA_W-1:DATA_W];
      default:  sel_w = en_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= sel_w;
    end
  end

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q));
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_cap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 16,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_strobe,
  input  logic [TIME_W-1:0] time_in,
  input  logic [SEQ_W-1:0]  seq_in,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [EN_W-1:0]   en_q;
  logic              cap_en;
  logic              clr;
  logic              valid_q;
  logic [TIME_W-1:0] time_q;
  logic [SEQ_W-1:0]  seq_q;
  logic              unused_wbits;

  always_comb unused_wbits = ^{reg_wdata[DATA_W-1:VALID_POS+1],
                               reg_wdata[VALID_POS-1:EN_W]};

  ts_cap_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wr_valid_bit (reg_wdata[VALID_POS]),
    .wr_en_bits   (reg_wdata[EN_W-1:0]),
    .en_q         (en_q),
    .cap_en       (cap_en),
    .clr          (clr)
  );

  ts_cap_latch #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .strobe  (cap_strobe),
    .time_in (time_in),
    .seq_in  (seq_in),
    .cap_en  (cap_en),
    .clr     (clr),
    .valid_q (valid_q),
    .time_q  (time_q),
    .seq_q   (seq_q)
  );

  ts_cap_rdmux #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .valid   (valid_q),
    .time_q  (time_q),
    .seq_q   (seq_q),
    .en_q    (en_q),
    .rdata_q (reg_rdata)
  );
endmodule

// File: tb/ts_capture_test.sv
module ts_capture_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_strobe = 1'b0;
  logic [63:0] time_in = '0;
  logic [15:0] seq_in = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic rd_dly = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ts_capture uut (
    .clk(clk), .rst(rst), .cap_strobe(cap_strobe), .time_in(time_in),
    .seq_in(seq_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rd_dly <= reg_rd;
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_dly) begin
      if (exp_q.size() == 0) begin
        compare(reg_rdata, 32'hxxxx_xxxx, "scoreboard underflow");
      end else begin
        compare(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe(input logic [63:0] t, input logic [15:0] s);
    @(negedge clk);
    cap_strobe = 1'b1; time_in = t; seq_in = s;
    @(negedge clk);
    cap_strobe = 1'b0;
  endtask

  task automatic strobe_and_clear(input logic [63:0] t, input logic [15:0] s);
    @(negedge clk);
    cap_strobe = 1'b1; time_in = t; seq_in = s;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0001_0000;
    @(negedge clk);
    cap_strobe = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, 32'h0, "R1 status");
    rd(2'd1, 32'h0, "R1 time low");
    rd(2'd2, 32'h0, "R1 time high");
    rd(2'd3, 32'h0, "R1 enable");
    // R6 disabled: strobe has no effect
    strobe(64'h1111_2222_3333_4444, 16'h00AA);
    rd(2'd0, 32'h0, "R6 disabled status");
    rd(2'd1, 32'h0, "R6 disabled time low");
    wr(2'd3, 32'h5);
    rd(2'd3, 32'h5, "R6 enable readback");
    // R2/R3 capture
    strobe(64'hDEAD_BEEF_0123_4567, 16'hFFFF);
    rd(2'd0, 32'h0001_FFFF, "R2 status");
    rd(2'd1, 32'h0123_4567, "R3 time low");
    rd(2'd2, 32'hDEAD_BEEF, "R3 time high");
    // R8 rdata holds without a read
    strobe(64'h5555_6666_7777_8888, 16'h1234);
    @(negedge clk);
    compare(reg_rdata, 32'hDEAD_BEEF, "R8 hold without read");
    // R4 ignored while valid
    rd(2'd0, 32'h0001_FFFF, "R4 status held");
    rd(2'd1, 32'h0123_4567, "R4 time low held");
    // R5 write without bit 16 does nothing
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, 32'h0001_FFFF, "R5 zero write ignored");
    wr(2'd0, 32'h0001_0000);
    rd(2'd0, 32'h0000_FFFF, "R5 cleared status");
    rd(2'd1, 32'h0123_4567, "R5 stale time low");
    // R6 enable 7 capture
    wr(2'd3, 32'h7);
    strobe(64'h0A0B_0C0D_1020_3040, 16'h0042);
    rd(2'd0, 32'h0001_0042, "R6 en7 status");
    rd(2'd2, 32'h0A0B_0C0D, "R6 en7 time high");
    // R7 clear and strobe together, flag set
    strobe_and_clear(64'hFFFF_0000_FFFF_0000, 16'h0099);
    rd(2'd0, 32'h0000_0042, "R7 set flag status");
    rd(2'd1, 32'h1020_3040, "R7 set flag time low");
    // R7 clear and strobe together, flag clear
    strobe_and_clear(64'h1234_5678_9ABC_DEF0, 16'h0077);
    rd(2'd0, 32'h0000_0042, "R7 clear flag status");
    // R6 enable 3 capture
    wr(2'd3, 32'h3);
    strobe(64'h0000_0001_0000_0002, 16'h0007);
    rd(2'd0, 32'h0001_0007, "R6 en3 status");
    rd(2'd1, 32'h0000_0002, "R6 en3 time low");
    // R6 re-disable blocks capture after re-arm
    wr(2'd0, 32'h0001_0000);
    wr(2'd3, 32'h0);
    strobe(64'hAAAA_BBBB_CCCC_DDDD, 16'h0011);
    rd(2'd0, 32'h0000_0007, "R6 re-disabled status");
    rd(2'd1, 32'h0000_0002, "R6 re-disabled time low");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) compare(32'(exp_q.size()), 32'h0, "scoreboard drain");
    finish_run();
  end
endmodule